// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block keeps the 64-byte type-0 configuration header of one PCI function. Software reaches it through a single-beat request port that carries an offset, a size code (byte, halfword or word), a write flag and write data. One cycle later the block answers with a response strobe, an error flag and read data. Reads may start at any offset. Bytes are assembled little-endian, and the bytes above the access width read as zero.

Writes follow per-register rules. A write lands only where the register and the access size allow it, and is dropped silently elsewhere. The six base address registers support the all-ones sizing handshake, and the expansion ROM register has its own probe value. The block also drives, for each base register, a decoded base address and a decode enable for a downstream address decoder. An enable rises only once software has placed a real address in the register and has switched on the matching space in the command register.

Top module: `pci_cfg_header`

## Requirements
- R1: Size code 0 selects 1 byte, 1 selects 2 bytes and 2 selects 4 bytes. Code 3 gives an error response, and neither a read nor a write takes effect.
- R2: An access whose last byte falls at offset 0x40 or above gives an error response with zero read data, and its write takes no effect.
- R3: A request is answered exactly one cycle later. Read data holds the bytes at offset .. offset+N-1, with the lowest-addressed byte in bits [7:0] and unused upper bytes zero. Error-free write responses carry zero data.
- R4: After reset, the header reads with this layout. Vendor is at 0x00 and device at 0x02, both 16 bits, and both come from parameters. Command is at 0x04 and status at 0x06, both reading 0. Revision, programming interface, subclass and class are at 0x08..0x0B. Cache line is at 0x0C and latency at 0x0D, both 0. Header type is at 0x0E. Base registers occupy 0x10..0x27. Subsystem vendor is at 0x2C and subsystem ID at 0x2E. The ROM register is at 0x30. Interrupt line is at 0x3C and reads 0. Interrupt pin, minimum grant and maximum latency are at 0x3D..0x3F.
- R5: A word write of 0xFFFFFFFF to an implemented, non-legacy base register makes it read ~(size-1) in its address bits, with its type bits unchanged.
- R6: Any other word write to such a base register replaces only the address bits. Bit 0 of the old value selects the kept type bits: bits [1:0] when bit 0 is 1 (I/O), or bits [3:0] when bit 0 is 0 (memory).
- R7: A base register whose size parameter is 0 reads 0, ignores writes and never asserts its decode enable.
- R8: A legacy base register reads 0 and ignores writes. It drives its fixed parameter address, with the type bits cleared, as its decode base, and its enable is high from the second cycle after reset.
- R9: A non-legacy decode enable is high only when the last write to that register was a non-sizing address write and the command register has bit 0 set (I/O register) or bit 1 set (memory register). The decode base is the stored value with the type bits cleared. Both outputs follow the register state one cycle later.
- R10: A word write of 0xFFFFFFFE to offset 0x30 makes the ROM register read 0xFFFFFFFF. Any other word write there is stored as written.
- R11: Byte writes update interrupt line (0x3C), cache line (0x0C) and latency (0x0D). Byte writes to any other offset, including revision, interrupt pin, minimum grant and maximum latency, are ignored.
- R12: A halfword or word write at 0x04 sets the 16-bit command register from data bits [15:0], and status stays 0. A halfword write at 0x0C sets cache line and latency. Word writes to offsets other than 0x04, the base registers and 0x30 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 invalid |
| req_offset | input | 8 | Byte offset into configuration space |
| req_wdata | input | 32 | Write data, lowest byte at the offset |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read data |
| bar_base_o | output | 192 | Decoded base address per base register, register i in bits [32i+31:32i] |
| bar_en_o | output | 6 | Decode enable per base register |

## Verification
A response is registered on the rising edge that samples its request. The scoreboard pushes the expected error flag and data when it drives a request. It pops and compares at the following falling edge, where the response strobe must be high. The decode base and enable outputs sit one more register behind the header state. The bench therefore samples them two falling edges after the write that changed them, which lets any off-by-one-cycle enable show up as a mismatch.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int NUM_BAR   = 6;
  localparam int HDR_BYTES = 64;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  localparam logic [7:0] OFF_CMD   = 8'h04;
  localparam logic [7:0] OFF_CLS   = 8'h0C;
  localparam logic [7:0] OFF_LAT   = 8'h0D;
  localparam logic [7:0] OFF_BAR0  = 8'h10;
  localparam logic [7:0] OFF_ROM   = 8'h30;
  localparam logic [7:0] OFF_ILINE = 8'h3C;

  localparam logic [31:0] BAR_PROBE = 32'hFFFF_FFFF;
  localparam logic [31:0] ROM_PROBE = 32'hFFFF_FFFE;

  function automatic logic [31:0] type_mask(input logic is_io);
    return is_io ? 32'h0000_0003 : 32'h0000_000F;
  endfunction
endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import pci_cfg_pkg::*;
#(
  parameter int unsigned SZ_LOG2 = 12,
  parameter logic [31:0] INIT    = 32'h0,
  parameter bit          LEGACY  = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        io_en,
  input  logic        mem_en,
  output logic [31:0] rd_value,
  output logic [31:0] dec_base,
  output logic        dec_en
);
  localparam bit          PRESENT    = (SZ_LOG2 != 0);
  localparam bit          LIVE       = PRESENT && !LEGACY;
  localparam logic [31:0] SIZE_MASK  = PRESENT ? ~((32'd1 << SZ_LOG2) - 32'd1) : 32'd0;
  localparam logic [31:0] FIXED_BASE = INIT & ~type_mask(INIT[0]);
  localparam logic [31:0] RESET_VAL  = LIVE ? INIT : 32'd0;

  logic [31:0] val_q;
  logic        addr_ok_q;
  logic [31:0] keep;
  logic        probe;
  logic [31:0] incoming;
  logic [31:0] val_next;

  always_comb begin
    keep     = type_mask(val_q[0]);
    probe    = (wdata == BAR_PROBE);
    incoming = probe ? SIZE_MASK : wdata;
    val_next = (incoming & ~keep) | (val_q & keep);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q     <= RESET_VAL;
      addr_ok_q <= 1'b0;
      dec_base  <= 32'd0;
      dec_en    <= 1'b0;
    end else begin
      if (wr_en && LIVE) begin
        val_q     <= val_next;
        addr_ok_q <= !probe;
      end
      dec_base <= LEGACY ? FIXED_BASE : (val_q & ~keep);
      dec_en   <= PRESENT &&
                  (LEGACY || (addr_ok_q && (val_q[0] ? io_en : mem_en)));
    end
  end

  assign rd_value = val_q;
endmodule

// File: rtl/cfg_rom_reg.sv
module cfg_rom_reg
  import pci_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] value
);
  always_ff @(posedge clk) begin
    if (rst) value <= 32'd0;
    else if (wr_en) value <= (wdata == ROM_PROBE) ? 32'hFFFF_FFFF : wdata;
  end
endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID     = 16'h7E01,
  parameter logic [7:0]  REVISION      = 8'h11,
  parameter logic [7:0]  PROG_IF       = 8'h00,
  parameter logic [7:0]  SUB_CLASS     = 8'h80,
  parameter logic [7:0]  BASE_CLASS    = 8'h02,
  parameter logic [7:0]  HEADER_TYPE   = 8'h00,
  parameter logic [15:0] SUBSYS_VENDOR = 16'hA5C3,
  parameter logic [15:0] SUBSYS_ID     = 16'h1001,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GNT       = 8'h04,
  parameter logic [7:0]  MAX_LAT       = 8'h20,
  parameter logic [NUM_BAR-1:0][4:0]  BAR_SZ_LOG2 =
    {5'd4, 5'd0, 5'd0, 5'd0, 5'd8, 5'd12},
  parameter logic [NUM_BAR-1:0][31:0] BAR_INIT =
    {32'h0000_01F1, 32'h0, 32'h0, 32'h0, 32'h0000_0001, 32'h0},
  parameter logic [NUM_BAR-1:0]       BAR_LEGACY = 6'b100000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic [7:0]             req_offset,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [31:0]            rsp_rdata,
  output logic [NUM_BAR*32-1:0]  bar_base_o,
  output logic [NUM_BAR-1:0]     bar_en_o
);
  localparam logic [8:0] HDR_END = 9'(HDR_BYTES);

  logic [15:0] cmd_q;
  logic [7:0]  cls_q, lat_q, iline_q;
  logic [31:0] rom_q;
  logic [31:0] bar_rd [NUM_BAR];
  logic [7:0]  hdr [HDR_BYTES];

  logic [2:0]  nbytes;
  logic [8:0]  last_byte;
  logic        acc_err;
  logic        wr_ok, byte_wr, half_wr, word_wr;
  logic [31:0] rd_word;

  // request decode
  always_comb begin
    unique case (acc_size_e'(req_size))
      SZ_BYTE: nbytes = 3'd1;
      SZ_HALF: nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
    last_byte = {1'b0, req_offset} + {6'd0, nbytes} - 9'd1;
    acc_err   = (acc_size_e'(req_size) == SZ_BAD) || (last_byte >= HDR_END);
    wr_ok     = req_valid && req_write && !acc_err;
    byte_wr   = wr_ok && (acc_size_e'(req_size) == SZ_BYTE);
    half_wr   = wr_ok && (acc_size_e'(req_size) == SZ_HALF);
    word_wr   = wr_ok && (acc_size_e'(req_size) == SZ_WORD);
  end

  // plain writable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= 16'd0;
      cls_q   <= 8'd0;
      lat_q   <= 8'd0;
      iline_q <= 8'd0;
    end else begin
      if (byte_wr && req_offset == OFF_CLS)   cls_q   <= req_wdata[7:0];
      if (byte_wr && req_offset == OFF_LAT)   lat_q   <= req_wdata[7:0];
      if (byte_wr && req_offset == OFF_ILINE) iline_q <= req_wdata[7:0];
      if ((half_wr || word_wr) && req_offset == OFF_CMD) cmd_q <= req_wdata[15:0];
      if (half_wr && req_offset == OFF_CLS) begin
        cls_q <= req_wdata[7:0];
        lat_q <= req_wdata[15:8];
      end
    end
  end

  // base address registers
  for (genvar gi = 0; gi < NUM_BAR; gi++) begin : g_bar
    localparam logic [7:0] SLOT_OFF = OFF_BAR0 + 8'(4 * gi);
    logic slot_wr;
    assign slot_wr = word_wr && (req_offset == SLOT_OFF);

    cfg_bar_slot #(
      .SZ_LOG2 (int'(BAR_SZ_LOG2[gi])),
      .INIT    (BAR_INIT[gi]),
      .LEGACY  (BAR_LEGACY[gi])
    ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (slot_wr),
      .wdata    (req_wdata),
      .io_en    (cmd_q[0]),
      .mem_en   (cmd_q[1]),
      .rd_value (bar_rd[gi]),
      .dec_base (bar_base_o[gi*32 +: 32]),
      .dec_en   (bar_en_o[gi])
    );
  end

  cfg_rom_reg u_rom (
    .clk   (clk),
    .rst   (rst),
    .wr_en (word_wr && (req_offset == OFF_ROM)),
    .wdata (req_wdata),
    .value (rom_q)
  );

  // byte image of the header
  always_comb begin
    for (int b = 0; b < HDR_BYTES; b++) hdr[b] = 8'h00;
    hdr[8'h00] = VENDOR_ID[7:0];
    hdr[8'h01] = VENDOR_ID[15:8];
    hdr[8'h02] = DEVICE_ID[7:0];
    hdr[8'h03] = DEVICE_ID[15:8];
    hdr[8'h04] = cmd_q[7:0];
    hdr[8'h05] = cmd_q[15:8];
    hdr[8'h08] = REVISION;
    hdr[8'h09] = PROG_IF;
    hdr[8'h0A] = SUB_CLASS;
    hdr[8'h0B] = BASE_CLASS;
    hdr[8'h0C] = cls_q;
    hdr[8'h0D] = lat_q;
    hdr[8'h0E] = HEADER_TYPE;
    for (int i = 0; i < NUM_BAR; i++)
      for (int j = 0; j < 4; j++)
        hdr[16 + 4*i + j] = bar_rd[i][8*j +: 8];
    hdr[8'h2C] = SUBSYS_VENDOR[7:0];
    hdr[8'h2D] = SUBSYS_VENDOR[15:8];
    hdr[8'h2E] = SUBSYS_ID[7:0];
    hdr[8'h2F] = SUBSYS_ID[15:8];
    for (int j = 0; j < 4; j++) hdr[48 + j] = rom_q[8*j +: 8];
    hdr[8'h3C] = iline_q;
    hdr[8'h3D] = INT_PIN;
    hdr[8'h3E] = MIN_GNT;
    hdr[8'h3F] = MAX_LAT;
  end

  // little-endian read lane assembly
  always_comb begin
    for (int k = 0; k < 4; k++)
      rd_word[8*k +: 8] = (3'(k) < nbytes) ? hdr[req_offset[5:0] + 6'(k)] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= 32'd0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && acc_err;
      rsp_rdata <= (req_valid && !req_write && !acc_err) ? rd_word : 32'd0;
    end
  end
endmodule

// File: rtl/cfg_hdr_checker.sv
module cfg_hdr_checker
  import pci_cfg_pkg::*;
#(
  parameter logic [NUM_BAR-1:0][4:0] BAR_SZ_LOG2 = '0,
  parameter logic [NUM_BAR-1:0]      BAR_LEGACY  = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic [1:0]         req_size,
  input logic [7:0]         req_offset,
  input logic [31:0]        req_wdata,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [31:0]        rsp_rdata,
  input logic [NUM_BAR-1:0] bar_en_o,
  input logic [15:0]        cmd_q,
  input logic [31:0]        rom_q
);
  assert_rsp_follows_req_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R3: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_bad_size_err_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd3) |=> rsp_err);
  assert_high_offset_err_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_offset >= 8'h40) |=> rsp_err);
  assert_err_zero_data_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));
  assert_rom_probe_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_size == 2'd2 && req_offset == 8'h30 &&
     req_wdata == 32'hFFFF_FFFE) |=> (rom_q == 32'hFFFF_FFFF));

  for (genvar gi = 0; gi < NUM_BAR; gi++) begin : g_chk
    if (BAR_SZ_LOG2[gi] == 5'd0) begin : g_absent
      assert_unimpl_bar_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !bar_en_o[gi]);
    end else if (!BAR_LEGACY[gi]) begin : g_live
      assert_en_needs_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_q[1:0] == 2'b00) |=> !bar_en_o[gi]);
    end
  end
endmodule

bind pci_cfg_header cfg_hdr_checker #(
  .BAR_SZ_LOG2 (BAR_SZ_LOG2),
  .BAR_LEGACY  (BAR_LEGACY)
) u_hdr_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_size   (req_size),
  .req_offset (req_offset),
  .req_wdata  (req_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_rdata  (rsp_rdata),
  .bar_en_o   (bar_en_o),
  .cmd_q      (cmd_q),
  .rom_q      (rom_q)
);

// File: tb/pci_cfg_header_test.sv
module pci_cfg_header_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [1:0]   req_size = 2'd0;
  logic [7:0]   req_offset = 8'd0;
  logic [31:0]  req_wdata = 32'd0;
  logic         rsp_valid, rsp_err;
  logic [31:0]  rsp_rdata;
  logic [191:0] bar_base_o;
  logic [5:0]   bar_en_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  typedef struct {
    logic        err;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  pci_cfg_header uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bar_base_o(bar_base_o), .bar_en_o(bar_en_o)
  );

  task automatic check(input string tag, input logic [191:0] act, input logic [191:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare on every response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check("R3 unexpected response", 192'(rsp_valid), 192'(0));
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " err"}, 192'(rsp_err), 192'(e.err));
        check({e.tag, " data"}, 192'(rsp_rdata), 192'(e.data));
      end
    end
  end

  task automatic access(input bit wr, input logic [1:0] sz, input logic [7:0] off,
                        input logic [31:0] wd, input bit e_err,
                        input logic [31:0] e_data, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_offset = off; req_wdata = wd;
    e.err = e_err; e.data = e_data; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [7:0] off,
                    input logic [31:0] exp, input string tag);
    access(1'b0, sz, off, 32'd0, 1'b0, exp, tag);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [7:0] off,
                    input logic [31:0] d, input string tag);
    access(1'b1, sz, off, d, 1'b0, 32'd0, tag);
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (sb_q.size() != 0) check("R3 responses still pending", 192'(sb_q.size()), 192'(0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    // R4 / R8 reset state
    check("R4 no response after reset", 192'(rsp_valid), 192'(0));
    check("R8 legacy enable after reset", 192'(bar_en_o), 192'(6'b100000));
    check("R8 legacy base", 192'(bar_base_o[5*32 +: 32]), 192'(32'h0000_01F0));
    rd(2'd2, 8'h00, 32'h7E01_A5C3, "R4 vendor/device");
    rd(2'd2, 8'h04, 32'h0000_0000, "R4 command/status");
    rd(2'd2, 8'h08, 32'h0280_0011, "R4 class word");
    rd(2'd2, 8'h0C, 32'h0000_0000, "R4 cache/latency/type");
    rd(2'd2, 8'h2C, 32'h1001_A5C3, "R4 subsystem");
    rd(2'd2, 8'h3C, 32'h2004_0100, "R4 interrupt word");
    rd(2'd2, 8'h30, 32'h0000_0000, "R4 rom reset");
    // R3 little-endian partial and unaligned reads
    rd(2'd0, 8'h02, 32'h0000_0001, "R3 byte read");
    rd(2'd1, 8'h01, 32'h0000_01A5, "R3 unaligned half");
    rd(2'd2, 8'h3A, 32'h0100_0000, "R3 unaligned word");
    // R1 invalid size
    access(1'b0, 2'd3, 8'h00, 32'd0, 1'b1, 32'd0, "R1 bad size read");
    access(1'b1, 2'd3, 8'h3C, 32'h55, 1'b1, 32'd0, "R1 bad size write");
    rd(2'd0, 8'h3C, 32'h0000_0000, "R1 bad size write dropped");
    // R2 out of range
    access(1'b0, 2'd2, 8'h40, 32'd0, 1'b1, 32'd0, "R2 word at 0x40");
    access(1'b0, 2'd2, 8'h3E, 32'd0, 1'b1, 32'd0, "R2 word spanning end");
    rd(2'd1, 8'h3E, 32'h0000_2004, "R2 half at top edge");
    access(1'b1, 2'd0, 8'h80, 32'h12, 1'b1, 32'd0, "R2 byte write far");
    // R5 sizing
    wr(2'd2, 8'h10, 32'hFFFF_FFFF, "R5 size mem bar");
    rd(2'd2, 8'h10, 32'hFFFF_F000, "R5 mem size mask");
    wr(2'd2, 8'h14, 32'hFFFF_FFFF, "R5 size io bar");
    rd(2'd2, 8'h14, 32'hFFFF_FF01, "R5 io size mask");
    // R6 address writes
    wr(2'd2, 8'h10, 32'h1234_567F, "R6 mem address");
    rd(2'd2, 8'h10, 32'h1234_5670, "R6 mem type bits kept");
    wr(2'd2, 8'h14, 32'h0000_C002, "R6 io address");
    rd(2'd2, 8'h14, 32'h0000_C001, "R6 io type bits kept");
    settle();
    check("R9 no enable without command", 192'(bar_en_o), 192'(6'b100000));
    // R9 / R12 command enables
    wr(2'd2, 8'h04, 32'hFFFF_0003, "R12 word command");
    settle();
    check("R9 both enabled", 192'(bar_en_o), 192'(6'b100011));
    check("R9 mem base", 192'(bar_base_o[0 +: 32]), 192'(32'h1234_5670));
    check("R9 io base", 192'(bar_base_o[32 +: 32]), 192'(32'h0000_C000));
    rd(2'd2, 8'h04, 32'h0000_0003, "R12 status stays zero");
    wr(2'd2, 8'h10, 32'hFFFF_FFFF, "R9 resize mem bar");
    settle();
    check("R9 sizing drops enable", 192'(bar_en_o), 192'(6'b100010));
    wr(2'd1, 8'h04, 32'h0000_0001, "R12 half command");
    wr(2'd2, 8'h10, 32'h0010_0000, "R9 mem address again");
    settle();
    check("R9 mem enable gated by cmd", 192'(bar_en_o), 192'(6'b100010));
    rd(2'd2, 8'h04, 32'h0000_0001, "R12 half command read");
    // R7 unimplemented
    wr(2'd2, 8'h18, 32'h5555_5550, "R7 write absent bar");
    rd(2'd2, 8'h18, 32'h0000_0000, "R7 absent bar reads zero");
    settle();
    check("R7 absent bar no enable", 192'(bar_en_o[2]), 192'(0));
    // R8 legacy
    wr(2'd2, 8'h24, 32'h0000_0301, "R8 write legacy");
    rd(2'd2, 8'h24, 32'h0000_0000, "R8 legacy reads zero");
    settle();
    check("R8 legacy base fixed", 192'(bar_base_o[5*32 +: 32]), 192'(32'h0000_01F0));
    check("R8 legacy enable held", 192'(bar_en_o[5]), 192'(1));
    // R10 ROM
    wr(2'd2, 8'h30, 32'hFFFF_FFFE, "R10 rom probe");
    rd(2'd2, 8'h30, 32'hFFFF_FFFF, "R10 rom all ones");
    wr(2'd2, 8'h30, 32'hABCD_0001, "R10 rom value");
    rd(2'd2, 8'h30, 32'hABCD_0001, "R10 rom stored");
    // R11 byte rules
    wr(2'd0, 8'h3C, 32'h0000_000B, "R11 int line");
    wr(2'd0, 8'h3D, 32'h0000_0077, "R11 int pin");
    wr(2'd0, 8'h08, 32'h0000_0099, "R11 revision");
    wr(2'd0, 8'h0C, 32'h0000_0010, "R11 cache line");
    wr(2'd0, 8'h0D, 32'h0000_0040, "R11 latency");
    rd(2'd2, 8'h3C, 32'h2004_010B, "R11 interrupt word");
    rd(2'd2, 8'h08, 32'h0280_0011, "R11 revision unchanged");
    rd(2'd2, 8'h0C, 32'h0000_4010, "R11 cache/latency");
    // R12 halfword and ignored word writes
    wr(2'd1, 8'h0C, 32'h0000_2208, "R12 half cache/latency");
    rd(2'd2, 8'h0C, 32'h0000_2208, "R12 half cache/latency read");
    wr(2'd2, 8'h00, 32'hDEAD_BEEF, "R12 word to id");
    rd(2'd2, 8'h00, 32'h7E01_A5C3, "R12 id unchanged");
    wr(2'd2, 8'h0C, 32'hFFFF_FFFF, "R12 word to 0x0C");
    rd(2'd2, 8'h0C, 32'h0000_2208, "R12 0x0C unchanged");
    settle();
    finished = 1'b1;
    summary();
  end
endmodule